// File: doc/BRIEF.md
# Diagnostic Video Path Capture Unit

This block sits on a video pixel path and provides the test capture registers used to debug it. A pixel-test register samples the incoming red/green/blue pixel port. A DAC-test register samples the word coming out of the palette lookup. A small control-test register samples the sync, blank and PLL-reference control bits. A two-bit mode input selects one of four behaviours.

In normal mode every register captures on every pixel clock. In edge-triggered mode captures happen only when the most significant red pixel bit changes in the selected direction, so a free-running clock can still be used to freeze one pixel. In loopback mode a host-written pixel-test value is sent into the palette path in place of the live pixel port. In override mode host-written DAC-test and control-test values drive the DAC and control outputs directly.

The host writes through simple write-enable and data ports. The captured values are always visible as outputs. Analog behaviour is outside this block.

Top module: `vpath_capture`

## Requirements
- R1: While reset (rst_ni low) is asserted, pt_cap_o, dt_cap_o and sbp_cap_o are all zero. The stored previous value of red bit 7 is also zero, so a high red bit 7 on the first clock after reset counts as a rising edge.
- R2: In mode 2'b00, every rising clock edge loads pt_cap_o with the pixel word, dt_cap_o with pal_data_i and sbp_cap_o with {sync_i, blank_i, pllref_i}.
- R3: In mode 2'b01 with trig_fall_i = 0, all three test registers capture only on a clock edge where red bit 7 is 1 and was 0 on the previous clock. On all other edges they hold.
- R4: In mode 2'b01 with trig_fall_i = 1, all three test registers capture only on a clock edge where red bit 7 is 0 and was 1 on the previous clock. A rising edge does not capture.
- R5: In mode 2'b01, a capture holds unchanged across any number of non-triggering clocks. A repeated trigger with the same pixel data loads the same value again.
- R6: In mode 2'b10, a pt_we_i pulse loads pt_wdata_i into pt_cap_o, and pal_in_o presents pt_cap_o instead of the live pixel port. The live pixel port is not captured. dt_cap_o and sbp_cap_o capture on every clock.
- R7: In mode 2'b11, dt_we_i loads dt_wdata_i and sbp_we_i loads sbp_wdata_i. dac_o shows dt_cap_o, ctl_o shows sbp_cap_o, and no register samples the live inputs.
- R8: Outside mode 2'b11, dac_o equals pal_data_i and ctl_o equals the live {sync_i, blank_i, pllref_i}. Outside mode 2'b10, pal_in_o equals the live pixel word.
- R9: pt_we_i has no effect outside mode 2'b10. dt_we_i and sbp_we_i have no effect outside mode 2'b11.
- R10: The pixel word is {pix_r_i, pix_g_i, pix_b_i} with red in the top bits, so red bit 7 is bit 23. The palette word is {red, green, blue} with 10 bits each. The control word has sync at bit 2, blank at bit 1 and PLL reference at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode: 00 normal, 01 edge-triggered, 10 loopback, 11 override |
| trig_fall_i | input | 1 | Edge-trigger polarity: 0 rising, 1 falling |
| pix_r_i | input | 8 | Red pixel input |
| pix_g_i | input | 8 | Green pixel input |
| pix_b_i | input | 8 | Blue pixel input |
| pal_data_i | input | 30 | Palette output word |
| sync_i | input | 1 | Live sync control bit |
| blank_i | input | 1 | Live blank control bit |
| pllref_i | input | 1 | Live PLL reference control bit |
| pt_we_i | input | 1 | Host write strobe, pixel-test register |
| pt_wdata_i | input | 24 | Host data, pixel-test register |
| dt_we_i | input | 1 | Host write strobe, DAC-test register |
| dt_wdata_i | input | 30 | Host data, DAC-test register |
| sbp_we_i | input | 1 | Host write strobe, control-test register |
| sbp_wdata_i | input | 3 | Host data, control-test register |
| pt_cap_o | output | 24 | Pixel-test register contents |
| dt_cap_o | output | 30 | DAC-test register contents |
| sbp_cap_o | output | 3 | Control-test register contents |
| pal_in_o | output | 24 | Pixel word sent toward the palette |
| dac_o | output | 30 | Word driven to the DACs |
| ctl_o | output | 3 | Control bits driven to the DACs |

## Verification
Normal mode is driven with distinct red, green and blue values on every clock. This exposes a lost capture or a swapped colour field. Edge-triggered mode is driven with red bit 7 held low, then rising, held high, falling and rising again with identical data, under both polarity settings. These sequences separate a level trigger, a wrong-direction trigger and a missing hold. Loopback and override are driven with host writes that differ from the live pixel and palette values, with write strobes also asserted in the wrong modes. This shows which source reaches each output and proves that the wrong-mode writes are ignored.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  typedef enum logic [1:0] {
    VPC_NORMAL = 2'b00,
    VPC_TRIG   = 2'b01,
    VPC_LOOP   = 2'b10,
    VPC_FORCE  = 2'b11
  } vpc_mode_e;

  typedef struct packed {
    logic pt_smp;   // pixel-test samples live pixel port
    logic pt_host;  // pixel-test loads host data
    logic dt_smp;   // DAC/control test registers sample live data
    logic dt_host;  // DAC-test loads host data
    logic sb_host;  // control-test loads host data
  } vpc_en_t;

  // edge of one bit, direction picked by fall
  function automatic logic edge_hit(input logic prev, input logic cur, input logic fall);
    return fall ? (prev & ~cur) : (~prev & cur);
  endfunction

  // capture enables for each mode
  function automatic vpc_en_t cap_enables(input vpc_mode_e mode, input logic trig,
                                          input logic pt_we, input logic dt_we,
                                          input logic sb_we);
    vpc_en_t e;
    e = '0;
    unique case (mode)
      VPC_NORMAL: begin
        e.pt_smp = 1'b1;
        e.dt_smp = 1'b1;
      end
      VPC_TRIG: begin
        e.pt_smp = trig;
        e.dt_smp = trig;
      end
      VPC_LOOP: begin
        e.pt_host = pt_we;
        e.dt_smp  = 1'b1;
      end
      VPC_FORCE: begin
        e.dt_host = dt_we;
        e.sb_host = sb_we;
      end
      default: e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/vpc_edge.sv
module vpc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic fall_i,
  output logic hit_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= bit_i;
  end

  assign hit_o = vpc_pkg::edge_hit(prev_q, bit_i, fall_i);

endmodule

// File: rtl/vpc_capreg.sv
module vpc_capreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         smp_en_i,
  input  logic [W-1:0] smp_d_i,
  input  logic         host_en_i,
  input  logic [W-1:0] host_d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= '0;
    else if (host_en_i) q_o <= host_d_i;
    else if (smp_en_i)  q_o <= smp_d_i;
  end

endmodule

// File: rtl/vpc_outmux.sv
module vpc_outmux #(
  parameter int PW = 24,
  parameter int DW = 30,
  parameter int CW = 3
) (
  input  logic [1:0]    mode_i,
  input  logic [PW-1:0] pix_live_i,
  input  logic [PW-1:0] pt_q_i,
  input  logic [DW-1:0] pal_i,
  input  logic [DW-1:0] dt_q_i,
  input  logic [CW-1:0] ctl_live_i,
  input  logic [CW-1:0] sb_q_i,
  output logic [PW-1:0] pal_in_o,
  output logic [DW-1:0] dac_o,
  output logic [CW-1:0] ctl_o
);
  import vpc_pkg::*;

  vpc_mode_e mode;
  assign mode = vpc_mode_e'(mode_i);

  always_comb begin
    pal_in_o = (mode == VPC_LOOP)  ? pt_q_i : pix_live_i;
    dac_o    = (mode == VPC_FORCE) ? dt_q_i : pal_i;
    ctl_o    = (mode == VPC_FORCE) ? sb_q_i : ctl_live_i;
  end

endmodule

// File: rtl/vpath_capture.sv
module vpath_capture #(
  parameter int CH_W  = 8,
  parameter int DAC_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mode_i,
  input  logic                 trig_fall_i,
  input  logic [CH_W-1:0]      pix_r_i,
  input  logic [CH_W-1:0]      pix_g_i,
  input  logic [CH_W-1:0]      pix_b_i,
  input  logic [3*DAC_W-1:0]   pal_data_i,
  input  logic                 sync_i,
  input  logic                 blank_i,
  input  logic                 pllref_i,
  input  logic                 pt_we_i,
  input  logic [3*CH_W-1:0]    pt_wdata_i,
  input  logic                 dt_we_i,
  input  logic [3*DAC_W-1:0]   dt_wdata_i,
  input  logic                 sbp_we_i,
  input  logic [2:0]           sbp_wdata_i,
  output logic [3*CH_W-1:0]    pt_cap_o,
  output logic [3*DAC_W-1:0]   dt_cap_o,
  output logic [2:0]           sbp_cap_o,
  output logic [3*CH_W-1:0]    pal_in_o,
  output logic [3*DAC_W-1:0]   dac_o,
  output logic [2:0]           ctl_o
);
  import vpc_pkg::*;

  localparam int PW = 3 * CH_W;
  localparam int DW = 3 * DAC_W;
  localparam int CW = 3;

  // named internal events
  logic [PW-1:0] pix_word;
  logic [CW-1:0] ctl_word;
  logic          trig_hit;
  vpc_en_t       en;

  assign pix_word = {pix_r_i, pix_g_i, pix_b_i};
  assign ctl_word = {sync_i, blank_i, pllref_i};

  vpc_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (pix_r_i[CH_W-1]),
    .fall_i (trig_fall_i),
    .hit_o  (trig_hit)
  );

  assign en = cap_enables(vpc_mode_e'(mode_i), trig_hit, pt_we_i, dt_we_i, sbp_we_i);

  vpc_capreg #(.W(PW)) u_pt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_en_i  (en.pt_smp),
    .smp_d_i   (pix_word),
    .host_en_i (en.pt_host),
    .host_d_i  (pt_wdata_i),
    .q_o       (pt_cap_o)
  );

  vpc_capreg #(.W(DW)) u_dt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_en_i  (en.dt_smp),
    .smp_d_i   (pal_data_i),
    .host_en_i (en.dt_host),
    .host_d_i  (dt_wdata_i),
    .q_o       (dt_cap_o)
  );

  vpc_capreg #(.W(CW)) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_en_i  (en.dt_smp),
    .smp_d_i   (ctl_word),
    .host_en_i (en.sb_host),
    .host_d_i  (sbp_wdata_i),
    .q_o       (sbp_cap_o)
  );

  vpc_outmux #(.PW(PW), .DW(DW), .CW(CW)) u_mux (
    .mode_i     (mode_i),
    .pix_live_i (pix_word),
    .pt_q_i     (pt_cap_o),
    .pal_i      (pal_data_i),
    .dt_q_i     (dt_cap_o),
    .ctl_live_i (ctl_word),
    .sb_q_i     (sbp_cap_o),
    .pal_in_o   (pal_in_o),
    .dac_o      (dac_o),
    .ctl_o      (ctl_o)
  );

endmodule

// File: rtl/vpc_capture_chk.sv
module vpc_capture_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  mode_i,
  input logic        trig_fall_i,
  input logic [23:0] pix_word,
  input logic [29:0] pal_data_i,
  input logic        trig_hit,
  input logic [23:0] pt_cap_o,
  input logic [29:0] dt_cap_o,
  input logic [2:0]  sbp_cap_o,
  input logic [23:0] pal_in_o,
  input logic [29:0] dac_o,
  input logic [2:0]  ctl_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (pt_cap_o == '0 && dt_cap_o == '0 && sbp_cap_o == '0));

  // R2
  normal_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> (pt_cap_o == $past(pix_word)));

  // R3
  trig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && !trig_hit) |=> ($stable(pt_cap_o) && $stable(dt_cap_o)));

  // R3
  trig_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && trig_hit) |=> (dt_cap_o == $past(pal_data_i)));

  // R4
  trig_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_hit |-> (trig_fall_i ? !pix_word[23] : pix_word[23]));

  // R6
  loop_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |-> (pal_in_o == pt_cap_o));

  // R7
  force_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> (dac_o == dt_cap_o && ctl_o == sbp_cap_o));

  // R9
  pt_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> $stable(pt_cap_o));

endmodule

bind vpath_capture vpc_capture_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .trig_fall_i (trig_fall_i),
  .pix_word    (pix_word),
  .pal_data_i  (pal_data_i),
  .trig_hit    (trig_hit),
  .pt_cap_o    (pt_cap_o),
  .dt_cap_o    (dt_cap_o),
  .sbp_cap_o   (sbp_cap_o),
  .pal_in_o    (pal_in_o),
  .dac_o       (dac_o),
  .ctl_o       (ctl_o)
);

// File: tb/test_vpath_capture.sv
module test_vpath_capture;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        tfall = 1'b0;
  logic [7:0]  pr = '0, pg = '0, pb = '0;
  logic [29:0] pal = '0;
  logic        sy = 1'b0, bl = 1'b0, pl = 1'b0;
  logic        ptwe = 1'b0, dtwe = 1'b0, sbwe = 1'b0;
  logic [23:0] ptd = '0;
  logic [29:0] dtd = '0;
  logic [2:0]  sbd = '0;
  logic [23:0] pt_cap, pal_in;
  logic [29:0] dt_cap, dac;
  logic [2:0]  sb_cap, ctl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  vpath_capture i_vpath_capture (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .trig_fall_i(tfall),
    .pix_r_i(pr), .pix_g_i(pg), .pix_b_i(pb), .pal_data_i(pal),
    .sync_i(sy), .blank_i(bl), .pllref_i(pl),
    .pt_we_i(ptwe), .pt_wdata_i(ptd), .dt_we_i(dtwe), .dt_wdata_i(dtd),
    .sbp_we_i(sbwe), .sbp_wdata_i(sbd),
    .pt_cap_o(pt_cap), .dt_cap_o(dt_cap), .sbp_cap_o(sb_cap),
    .pal_in_o(pal_in), .dac_o(dac), .ctl_o(ctl)
  );

  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t q[$];

  // bench model state
  logic [23:0] m_pt = '0;
  logic [29:0] m_dt = '0;
  logic [2:0]  m_sb = '0;
  logic        m_r7 = 1'b0;

  function automatic logic [31:0] actual(int sel);
    case (sel)
      0: return {8'h0, pt_cap};
      1: return {2'h0, dt_cap};
      2: return {29'h0, sb_cap};
      3: return {8'h0, pal_in};
      4: return {2'h0, dac};
      default: return {29'h0, ctl};
    endcase
  endfunction

  function automatic string sel_name(int sel);
    case (sel)
      0: return "pt_cap";
      1: return "dt_cap";
      2: return "sbp_cap";
      3: return "pal_in";
      4: return "dac";
      default: return "ctl";
    endcase
  endfunction

  task automatic push(string tag, int sel, logic [31:0] e);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = e;
    q.push_back(it);
  endtask

  // driver: inputs already set; predict the state after the next edge
  task automatic tick(string tag);
    logic [23:0] pix;
    logic [2:0]  cw;
    logic        r7, trig;
    pix  = {pr, pg, pb};          // R10 layout
    cw   = {sy, bl, pl};
    r7   = pr[7];
    trig = tfall ? (m_r7 && !r7) : (!m_r7 && r7);
    case (mode)
      2'b00: begin m_pt = pix; m_dt = pal; m_sb = cw; end
      2'b01: if (trig) begin m_pt = pix; m_dt = pal; m_sb = cw; end
      2'b10: begin m_dt = pal; m_sb = cw; if (ptwe) m_pt = ptd; end
      default: begin if (dtwe) m_dt = dtd; if (sbwe) m_sb = sbd; end
    endcase
    m_r7 = r7;
    push(tag, 0, {8'h0, m_pt});
    push(tag, 1, {2'h0, m_dt});
    push(tag, 2, {29'h0, m_sb});
    push(tag, 3, {8'h0, (mode == 2'b10) ? m_pt : pix});
    push(tag, 4, {2'h0, (mode == 2'b11) ? m_dt : pal});
    push(tag, 5, {29'h0, (mode == 2'b11) ? m_sb : cw});
    @(negedge clk);
  endtask

  // monitor: compare after each edge settles
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (actual(it.sel) !== it.exp) begin
          errors++;
          $display("FAIL %s %s actual %h expected %h", it.tag, sel_name(it.sel),
                   actual(it.sel), it.exp);
        end
      end
    end
  end

  task automatic set_pix(logic [7:0] r, logic [7:0] g, logic [7:0] b, logic [29:0] p, logic [2:0] c);
    pr = r; pg = g; pb = b; pal = p; {sy, bl, pl} = c;
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    set_pix(8'hFF, 8'h12, 8'h34, 30'h2AAAAAAA, 3'b111);
    push("R1", 0, 32'h0); push("R1", 1, 32'h0); push("R1", 2, 32'h0);
    @(negedge clk);
    push("R1", 0, 32'h0); push("R1", 1, 32'h0); push("R1", 2, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    set_pix(8'h00, 8'h00, 8'h00, 30'h0, 3'b000);

    // R2 / R8 / R10: normal mode, distinct colour fields
    mode = 2'b00;
    set_pix(8'hA1, 8'hB2, 8'hC3, 30'h1234_5678, 3'b100); tick("R2");
    set_pix(8'h11, 8'h22, 8'h33, 30'h0ABC_DEF0, 3'b010); tick("R10");
    set_pix(8'h7E, 8'h00, 8'hFF, 30'h3FFF_0001, 3'b001); tick("R8");
    // R9: dt/sbp writes ignored in normal mode
    dtwe = 1; dtd = 30'h1111_1111; sbwe = 1; sbd = 3'b101;
    set_pix(8'h05, 8'h06, 8'h07, 30'h0222_0333, 3'b010); tick("R9");
    dtwe = 0; sbwe = 0;

    // R3 / R5: rising trigger
    mode = 2'b01; tfall = 0;
    set_pix(8'h10, 8'h20, 8'h30, 30'h0000_1111, 3'b000); tick("R3");
    set_pix(8'h11, 8'h21, 8'h31, 30'h0000_2222, 3'b001); tick("R3");
    set_pix(8'h90, 8'h40, 8'h50, 30'h0000_3333, 3'b110); tick("R3");
    set_pix(8'h91, 8'h41, 8'h51, 30'h0000_4444, 3'b011); tick("R5");
    set_pix(8'hF0, 8'h42, 8'h52, 30'h0000_5555, 3'b000); tick("R5");
    // R9: dt write ignored in trigger mode without trigger
    dtwe = 1; dtd = 30'h2BAD_BEEF;
    set_pix(8'h01, 8'h43, 8'h53, 30'h0000_6666, 3'b101); tick("R9");
    dtwe = 0;
    set_pix(8'h90, 8'h40, 8'h50, 30'h0000_3333, 3'b110); tick("R5");
    set_pix(8'h00, 8'h40, 8'h50, 30'h0000_3333, 3'b110); tick("R5");
    set_pix(8'h90, 8'h40, 8'h50, 30'h0000_3333, 3'b110); tick("R5");

    // R4: falling trigger
    tfall = 1;
    set_pix(8'h85, 8'h66, 8'h77, 30'h0100_0000, 3'b001); tick("R4");
    set_pix(8'h05, 8'h67, 8'h78, 30'h0200_0000, 3'b010); tick("R4");
    set_pix(8'h06, 8'h68, 8'h79, 30'h0300_0000, 3'b100); tick("R4");
    set_pix(8'h86, 8'h69, 8'h7A, 30'h0400_0000, 3'b111); tick("R4");
    set_pix(8'h87, 8'h6A, 8'h7B, 30'h0500_0000, 3'b000); tick("R4");
    tfall = 0;

    // R6: loopback
    mode = 2'b10;
    set_pix(8'hDE, 8'hAD, 8'hBE, 30'h0600_0006, 3'b011); tick("R6");
    ptwe = 1; ptd = 24'hC0FFEE;
    set_pix(8'h12, 8'h34, 8'h56, 30'h0700_0007, 3'b101); tick("R6");
    ptwe = 0;
    set_pix(8'h9A, 8'hBC, 8'hDE, 30'h0800_0008, 3'b110); tick("R6");
    // R9: dt write ignored in loopback
    dtwe = 1; dtd = 30'h3000_0003;
    set_pix(8'h00, 8'h11, 8'h22, 30'h0900_0009, 3'b000); tick("R9");
    dtwe = 0;

    // R7: override
    mode = 2'b11;
    set_pix(8'h44, 8'h55, 8'h66, 30'h0A00_000A, 3'b111); tick("R7");
    dtwe = 1; dtd = 30'h3ABC_1234; sbwe = 1; sbd = 3'b010;
    set_pix(8'h45, 8'h56, 8'h67, 30'h0B00_000B, 3'b101); tick("R7");
    dtwe = 0; sbwe = 0;
    set_pix(8'hC5, 8'h57, 8'h68, 30'h0C00_000C, 3'b001); tick("R7");
    // R9: pixel-test write ignored in override
    ptwe = 1; ptd = 24'h123456;
    set_pix(8'h46, 8'h58, 8'h69, 30'h0D00_000D, 3'b000); tick("R9");
    ptwe = 0;

    // R8: back to normal, outputs follow live inputs again
    mode = 2'b00;
    set_pix(8'h3C, 8'h5A, 8'h96, 30'h0E00_000E, 3'b110); tick("R8");
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule